// File: doc/BRIEF.md
# Receive Interrupt and DMA Handshake Controller

This block sits next to a UART receive path that holds incoming bytes either in a FIFO or in a single holding register. It turns the receive-side settings and the buffer state into three registered outputs. The first is a receive interrupt pending bit. The second is a receive-timeout status bit. The third is a level DMA-busy line that tells an external DMA controller whether there is anything to fetch.

When the receive path is in DMA mode and the buffer is empty, the busy line is high. This stops the DMA controller from issuing reads that would find no data. The block keeps the busy line in step with data arrivals, reads of the receive data register, trigger-level events and idle-timeout events. It also tracks the data-ready flag of the holding register that is used when the FIFO is off.

The register interface clears the pending and timeout bits with a write-one-to-clear strobe. The serializer, the baud generator, the FIFO storage and the DMA engine all sit outside this block.

Top module: `rx_irq_dma_ctl`

## Requirements
- R1: `rx_mode` selects receive DMA only at code 2'b10. With any other code, `dma_busy` is low one edge later, whatever the buffer state.
- R2: In DMA mode, `dma_busy` goes high one edge after the buffer is empty and low one edge after it holds data. Empty means `fifo_count`==0 when `fifo_en`=1, and a clear data-ready flag when `fifo_en`=0.
- R3: With `fifo_en`=1 and `lvl_only`=0, a non-zero `fifo_count` sets `rx_pend` at the next edge.
- R4: With `fifo_en`=1, `fifo_count` >= (`trig_sel`+1)*DEPTH/8 sets `rx_pend` at the next edge whatever `lvl_only` is. For DEPTH 16 the thresholds are 2, 4, 6 up to 16. A count one below the threshold with `lvl_only`=1 leaves `rx_pend` clear.
- R5: With `fifo_en`=0, a `hold_load` pulse sets the data-ready flag. While the flag is set, `rx_pend` is set at the edge after it was set.
- R6: With `fifo_en`=0, a `rd_strobe` clears the data-ready flag unless `hold_load` arrives in the same cycle. In DMA mode this raises `dma_busy` at the next edge.
- R7: An `idle_tick` sets both `rx_pend` and `rx_tmo` at the next edge when all of these hold: `tmo_en`=1, `fifo_en`=1, `fifo_count` non-zero and `rx_pend` clear.
- R8: An `idle_tick` is ignored, leaving `rx_tmo` unchanged, while `rx_pend` is already set, while `tmo_en`=0 or while the FIFO is empty.
- R9: `int_clr` clears `rx_pend` and `rx_tmo` at the next edge. A set condition in the same cycle wins.
- R10: A synchronous active-high `rst` clears `rx_pend`, `rx_tmo`, the data-ready flag and `dma_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_mode | input | 2 | Receive mode field; 2'b10 selects DMA |
| fifo_en | input | 1 | FIFO mode enable |
| lvl_only | input | 1 | When set, only the trigger level raises the FIFO interrupt |
| tmo_en | input | 1 | Idle-timeout interrupt enable |
| trig_sel | input | 3 | Encoded FIFO trigger level |
| fifo_count | input | CNT_W | Current FIFO occupancy |
| hold_load | input | 1 | Byte written into the holding register (non-FIFO mode) |
| idle_tick | input | 1 | Idle-timeout expiry pulse |
| rd_strobe | input | 1 | Read of the receive data register |
| int_clr | input | 1 | Write-one-to-clear of pending and timeout bits |
| dma_busy | output | 1 | High when DMA mode is on and the buffer is empty |
| rx_pend | output | 1 | Receive interrupt pending |
| rx_tmo | output | 1 | Receive timeout status |

## Verification
Random mixes of FIFO counts, trigger codes, mode codes and sparse timeout, clear, load and read pulses are applied. They show whether the level, non-empty and timeout raise paths combine in the right way and whether the busy line follows the buffer state in each mode. Directed sequences put a count one below the threshold and then on it, so that a threshold that is off by one shows up. A timeout arriving after an interrupt has already fired checks the cancellation rule. A clear strobe that meets a live raise condition shows which of the two wins. A load and a read of the holding register in DMA mode check that the busy line drops and then rises again.

// File: rtl/rxh_pkg.sv
package rxh_pkg;
  typedef enum logic [1:0] {
    RXM_OFF  = 2'b00,
    RXM_IRQ  = 2'b01,
    RXM_DMA  = 2'b10,
    RXM_RSVD = 2'b11
  } rx_mode_e;

  localparam int SEL_W  = 3;
  localparam int N_LVLS = 1 << SEL_W;
endpackage

// File: rtl/rxh_trig_dec.sv
module rxh_trig_dec #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [rxh_pkg::SEL_W-1:0] sel,
  output logic [CNT_W-1:0]          level
);
  logic [CNT_W-1:0] tbl [rxh_pkg::N_LVLS];

  for (genvar i = 0; i < rxh_pkg::N_LVLS; i++) begin : g_lvl
    localparam int LV = ((i + 1) * DEPTH) / rxh_pkg::N_LVLS;
    assign tbl[i] = CNT_W'(LV);
  end

  assign level = tbl[sel];
endmodule

// File: rtl/rxh_flags.sv
module rxh_flags #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             lvl_only,
  input  logic             tmo_en,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [CNT_W-1:0] level,
  input  logic             hold_load,
  input  logic             idle_tick,
  input  logic             rd_strobe,
  input  logic             int_clr,
  output logic             dr_next,
  output logic             rx_pend,
  output logic             rx_tmo
);
  logic dr_q;
  logic nonempty;
  logic fifo_raise;
  logic hold_raise;
  logic tmo_hit;

  assign nonempty = (fifo_count != '0);

  always_comb begin
    dr_next = dr_q;
    if (rd_strobe && !fifo_en) dr_next = 1'b0;
    if (hold_load)             dr_next = 1'b1;
  end

  assign fifo_raise = fifo_en && ((nonempty && !lvl_only) || (fifo_count >= level));
  assign hold_raise = !fifo_en && dr_next;
  assign tmo_hit    = idle_tick && tmo_en && fifo_en && nonempty && !rx_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      dr_q    <= 1'b0;
      rx_pend <= 1'b0;
      rx_tmo  <= 1'b0;
    end else begin
      dr_q    <= dr_next;
      rx_pend <= (rx_pend && !int_clr) || fifo_raise || hold_raise || tmo_hit;
      rx_tmo  <= (rx_tmo && !int_clr) || tmo_hit;
    end
  end
endmodule

// File: rtl/rxh_busy.sv
module rxh_busy #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       rx_mode,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             dr_next,
  output logic             dma_busy
);
  import rxh_pkg::*;

  logic dma_sel;
  logic empty;

  assign dma_sel = (rx_mode_e'(rx_mode) == RXM_DMA);
  assign empty   = fifo_en ? (fifo_count == '0) : !dr_next;

  always_ff @(posedge clk) begin
    if (rst) dma_busy <= 1'b0;
    else     dma_busy <= dma_sel && empty;
  end
endmodule

// File: rtl/rx_irq_dma_ctl.sv
module rx_irq_dma_ctl #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       rx_mode,
  input  logic             fifo_en,
  input  logic             lvl_only,
  input  logic             tmo_en,
  input  logic [2:0]       trig_sel,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             hold_load,
  input  logic             idle_tick,
  input  logic             rd_strobe,
  input  logic             int_clr,
  output logic             dma_busy,
  output logic             rx_pend,
  output logic             rx_tmo
);
  logic [CNT_W-1:0] level;
  logic             dr_next;

  rxh_trig_dec #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dec (
    .sel   (trig_sel),
    .level (level)
  );

  rxh_flags #(.CNT_W(CNT_W)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .lvl_only   (lvl_only),
    .tmo_en     (tmo_en),
    .fifo_count (fifo_count),
    .level      (level),
    .hold_load  (hold_load),
    .idle_tick  (idle_tick),
    .rd_strobe  (rd_strobe),
    .int_clr    (int_clr),
    .dr_next    (dr_next),
    .rx_pend    (rx_pend),
    .rx_tmo     (rx_tmo)
  );

  rxh_busy #(.CNT_W(CNT_W)) u_busy (
    .clk        (clk),
    .rst        (rst),
    .rx_mode    (rx_mode),
    .fifo_en    (fifo_en),
    .fifo_count (fifo_count),
    .dr_next    (dr_next),
    .dma_busy   (dma_busy)
  );
endmodule

// File: rtl/rx_irq_dma_ctl_chk.sv
module rx_irq_dma_ctl_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       rx_mode,
  input logic             fifo_en,
  input logic [CNT_W-1:0] fifo_count,
  input logic             hold_load,
  input logic             idle_tick,
  input logic             int_clr,
  input logic             dma_busy,
  input logic             rx_pend,
  input logic             rx_tmo
);
  // R1: busy only follows a DMA mode code on the previous cycle
  a_r1_busy_needs_dma: assert property (@(posedge clk) disable iff (rst)
    dma_busy |-> ($past(rx_mode) == 2'b10));

  // R4: a full FIFO always meets any trigger level
  a_r4_full_raises: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && fifo_count == CNT_W'(DEPTH)) |=> rx_pend);

  // R5: a byte landing in the holding register makes busy drop
  a_r5_load_ready: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && hold_load) |=> !dma_busy);

  // R7: timeout status never rises without the pending bit
  a_r7_tmo_with_pend: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_tmo) |-> rx_pend);

  // R8: a timeout tick while pending is set leaves timeout status unchanged
  a_r8_tick_cancelled: assert property (@(posedge clk) disable iff (rst)
    (idle_tick && rx_pend && !int_clr) |=> $stable(rx_tmo));

  // R10: reset clears every output
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!dma_busy && !rx_pend && !rx_tmo));
endmodule

bind rx_irq_dma_ctl rx_irq_dma_ctl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rx_mode    (rx_mode),
  .fifo_en    (fifo_en),
  .fifo_count (fifo_count),
  .hold_load  (hold_load),
  .idle_tick  (idle_tick),
  .int_clr    (int_clr),
  .dma_busy   (dma_busy),
  .rx_pend    (rx_pend),
  .rx_tmo     (rx_tmo)
);

// File: tb/rx_irq_dma_ctl_test.sv
module rx_irq_dma_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int CNT_W      = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst;
  logic [1:0]       rx_mode;
  logic             fifo_en, lvl_only, tmo_en;
  logic [2:0]       trig_sel;
  logic [CNT_W-1:0] fifo_count;
  logic             hold_load, idle_tick, rd_strobe, int_clr;
  logic             dma_busy, rx_pend, rx_tmo;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  bit m_dr, m_pend, m_tmo, m_busy;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_irq_dma_ctl #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .rx_mode(rx_mode), .fifo_en(fifo_en),
    .lvl_only(lvl_only), .tmo_en(tmo_en), .trig_sel(trig_sel),
    .fifo_count(fifo_count), .hold_load(hold_load), .idle_tick(idle_tick),
    .rd_strobe(rd_strobe), .int_clr(int_clr), .dma_busy(dma_busy),
    .rx_pend(rx_pend), .rx_tmo(rx_tmo)
  );

  function automatic int thr(input logic [2:0] s);
    return ((int'(s) + 1) * DEPTH) / 8;
  endfunction

  task automatic model_edge();
    bit dn, raise, hit;
    if (rst) begin
      m_dr = 0; m_pend = 0; m_tmo = 0; m_busy = 0;
      return;
    end
    dn = m_dr;
    if (rd_strobe && !fifo_en) dn = 0;
    if (hold_load) dn = 1;
    raise = fifo_en ? ((fifo_count != 0 && !lvl_only) || int'(fifo_count) >= thr(trig_sel)) : dn;
    hit = idle_tick && tmo_en && fifo_en && fifo_count != 0 && !m_pend;
    m_busy = (rx_mode == 2'b10) && (fifo_en ? (fifo_count == 0) : !dn);
    m_tmo  = (m_tmo && !int_clr) || hit;
    m_pend = (m_pend && !int_clr) || raise || hit;
    m_dr   = dn;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    n_checks++;
    if ({dma_busy, rx_pend, rx_tmo} !== {m_busy, m_pend, m_tmo}) begin
      n_fail++;
      $display("FAIL %s: busy/pend/tmo actual %b%b%b expected %b%b%b", tag,
               dma_busy, rx_pend, rx_tmo, m_busy, m_pend, m_tmo);
    end
    hold_load = 0; idle_tick = 0; rd_strobe = 0; int_clr = 0;
  endtask

  task automatic idle_inputs();
    rx_mode = 2'b10; fifo_en = 1; lvl_only = 0; tmo_en = 0; trig_sel = 0;
    fifo_count = 0; hold_load = 0; idle_tick = 0; rd_strobe = 0; int_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle_inputs();
    rst = 1;
    step("R10 reset");
    step("R10 reset hold");
    rst = 0;

    // R2: DMA mode with empty FIFO -> busy
    step("R2 empty busy");
    fifo_count = 3;
    step("R2 data ready");
    // R1: non-DMA code keeps busy low
    fifo_count = 0; rx_mode = 2'b01;
    step("R1 mode 01 idle");
    rx_mode = 2'b11;
    step("R1 mode 11 idle");
    rx_mode = 2'b10;
    int_clr = 1;
    step("R9 clear");

    // R4: threshold boundary with level-only mode, trig_sel 3 -> 8
    lvl_only = 1; trig_sel = 3; fifo_count = 7;
    step("R4 below level");
    fifo_count = 8;
    step("R4 at level");
    // R9: clear while raise holds -> set wins
    int_clr = 1;
    step("R9 set wins");
    // R8: tick while pending is ignored
    tmo_en = 1; idle_tick = 1;
    step("R8 tick while pending");
    fifo_count = 1; int_clr = 1;
    step("R9 clear below level");
    // R7: tick with data, pending clear
    idle_tick = 1;
    step("R7 timeout fires");
    int_clr = 1; fifo_count = 0;
    step("R9 clear timeout");
    // R8: tick on empty FIFO ignored
    idle_tick = 1;
    step("R8 empty tick");
    tmo_en = 0; fifo_count = 2; idle_tick = 1;
    step("R8 disabled tick");
    // R3: non-empty raise without level-only
    lvl_only = 0; fifo_count = 1; trig_sel = 7; int_clr = 1;
    step("R3 clear first");
    step("R3 nonempty raise");

    // R5/R6: holding register path in DMA mode
    fifo_en = 0; fifo_count = 0; int_clr = 1;
    step("R6 empty holding busy");
    hold_load = 1;
    step("R5 load ready");
    step("R5 pend from data ready");
    rd_strobe = 1; int_clr = 1;
    step("R6 read clears ready");
    hold_load = 1; rd_strobe = 1;
    step("R6 load beats read");

    // random mix
    for (int i = 0; i < 400; i++) begin
      rx_mode    = 2'($urandom_range(0, 3));
      fifo_en    = ($urandom_range(0, 3) != 0);
      lvl_only   = 1'($urandom);
      tmo_en     = 1'($urandom);
      trig_sel   = 3'($urandom);
      fifo_count = CNT_W'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 2) == 0) fifo_count = 0;
      hold_load  = ($urandom_range(0, 5) == 0);
      rd_strobe  = ($urandom_range(0, 4) == 0);
      idle_tick  = ($urandom_range(0, 4) == 0);
      int_clr    = ($urandom_range(0, 3) == 0);
      step("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    rst = 1;
    step("R10 reset again");
    rst = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule